// File: doc/BRIEF.md
# Factory Buffered Program Engine

This block is a programming sequencer for a flash array in high-volume production. A host enters the mode with one two-write command pair aimed at the start of a block. From then on the host only streams data: it writes a full buffer of words, polls one status bit until the engine has moved that buffer into the array, then writes the next buffer. The engine keeps its own array address, which steps forward by one buffer length after every buffer. The host therefore never sends another command, a word count or an address offset until the whole block is done.

Each word is written to the array and read back straight away. A word that does not read back correctly is programmed again, a bounded number of times, before the engine gives up and reports a program failure. The mode ends by itself after the last buffer of the block. The host can also leave early by writing the all-ones word to any address outside the active block. In either case the engine returns to the ready state. The status byte always shows the ready, busy and error conditions.

Top module: `fbp_engine`

## Requirements
- R1: After reset the status byte reads 0x80 (bit 7 ready, all else 0) and no array program strobe is issued.
- R2: Writing data 0x0080 and then 0x00D0 to the same buffer-aligned address (a multiple of BUF_WORDS) enters the mode. The status byte then reads 0x00.
- R3: If the confirm write carries data other than 0x00D0, goes to a different address, or the setup address is not buffer-aligned, the engine returns to ready with a sequence error: status 0xB0 (bits 7, 5, 4). No array word is programmed.
- R4: In the mode, each write to an address inside the active block stores the next buffer word. Once BUF_WORDS words are stored, status bit 0 reads 1 from the next cycle until the buffer is in the array. After that it reads 0 again, with bit 7 still 0.
- R5: Word i of buffer k (counting from 0) is programmed at block base + k*BUF_WORDS + i. No address outside the block is ever programmed.
- R6: Each programmed word is read back. On a mismatch it is programmed again, up to MAX_RETRY extra attempts (default 3). A word that matches on its last allowed attempt is accepted without error.
- R7: If a word still mismatches after MAX_RETRY retries, the engine ends the mode with status 0x90 (bits 7, 4). Later data writes program nothing.
- R8: In the fill phase, writing 0xFFFF to an address outside the active block leaves the mode with status 0x80. The words of a partly filled buffer are discarded. Writing 0xFFFF inside the block is stored as ordinary data.
- R9: After the last buffer of the block is programmed, the engine returns to ready with status 0x80 and no error bit.
- R10: Writes that arrive while a buffer is being programmed are ignored. Writes outside the block with data other than 0xFFFF are also ignored in the fill phase. Neither changes the array contents or the status.
- R11: A new setup write of 0x0080 clears both error bits, so the status reads 0x00 during setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe, one word per cycle |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | 16 | Host write data or command code |
| sts | output | 8 | Status: bit 7 ready, bit 5 sequence error, bit 4 program error, bit 0 buffer busy |
| arr_we | output | 1 | Array program strobe, one cycle per attempt |
| arr_addr | output | ADDR_W | Array word address for program and read-back |
| arr_wdata | output | 16 | Word being programmed |
| arr_rdata | input | 16 | Array read-back of arr_addr, combinational |

## Verification
The hardest cases to reach from the ports are the retry boundaries: a word that fails exactly MAX_RETRY times and then passes, and one that fails once more than that. A correct array never produces either. The bench's array model therefore holds a fault counter. This counter corrupts the stored value at one chosen address for a chosen number of program attempts. The bench then counts program strobes to confirm that the retries took place and that the engine either accepted the word or stopped with a program error.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

    localparam int DATA_W = 16;

    localparam logic [DATA_W-1:0] CMD_SETUP   = 16'h0080;
    localparam logic [DATA_W-1:0] CMD_CONFIRM = 16'h00D0;
    localparam logic [DATA_W-1:0] CMD_LEAVE   = 16'hFFFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_FILL,
        ST_PGM,
        ST_VFY
    } fbp_state_e;

    typedef struct packed {
        logic ready;
        logic seq_err;
        logic pgm_err;
        logic busy;
    } fbp_flags_t;

    function automatic logic [7:0] pack_status(input fbp_flags_t f);
        return {f.ready, 1'b0, f.seq_err, f.pgm_err, 3'b000, f.busy};
    endfunction

    function automatic logic is_aligned(input logic [31:0] a, input int unsigned words);
        return (a % words) == 0;
    endfunction

endpackage

// File: rtl/fbp_wbuf.sv
module fbp_wbuf #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 256
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     last_wr
);
    localparam int IW = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [IW-1:0]     wr_idx;

    assign last_wr = wr_en && (wr_idx == IW'(DEPTH - 1));
    assign rd_data = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_idx <= '0;
        end else if (wr_en) begin
            wr_idx <= last_wr ? '0 : wr_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

endmodule

// File: rtl/fbp_addr_gen.sv
module fbp_addr_gen #(
    parameter int ADDR_W      = 16,
    parameter int BUF_WORDS   = 256,
    parameter int BLOCK_WORDS = 1024
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load,
    input  logic [ADDR_W-1:0]            load_addr,
    input  logic                         word_inc,
    input  logic                         chunk_adv,
    input  logic [ADDR_W-1:0]            probe_addr,
    output logic [ADDR_W-1:0]            base,
    output logic [ADDR_W-1:0]            arr_addr,
    output logic [$clog2(BUF_WORDS)-1:0] word_idx,
    output logic                         probe_in_block,
    output logic                         last_word,
    output logic                         last_chunk
);
    localparam int NCHUNK = BLOCK_WORDS / BUF_WORDS;
    localparam int WW     = $clog2(BUF_WORDS);
    localparam int CW     = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;

    logic [CW-1:0]     chunk;
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W:0]   limit;

    assign offset     = ADDR_W'(chunk) * ADDR_W'(BUF_WORDS) + ADDR_W'(word_idx);
    assign arr_addr   = base + offset;
    assign last_word  = (word_idx == WW'(BUF_WORDS - 1));
    assign last_chunk = (chunk == CW'(NCHUNK - 1));
    assign limit      = {1'b0, base} + (ADDR_W + 1)'(BLOCK_WORDS);
    assign probe_in_block = (probe_addr >= base) && ({1'b0, probe_addr} < limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            base     <= '0;
            chunk    <= '0;
            word_idx <= '0;
        end else if (load) begin
            base     <= load_addr;
            chunk    <= '0;
            word_idx <= '0;
        end else if (chunk_adv) begin
            chunk    <= chunk + 1'b1;
            word_idx <= '0;
        end else if (word_inc) begin
            word_idx <= word_idx + 1'b1;
        end
    end

    AST_OFFSET_IN_BLOCK: assert property (@(posedge clk) disable iff (rst)
        offset < ADDR_W'(BLOCK_WORDS)); // R5

    AST_CHUNK_FROZEN_IN_BUFFER: assert property (@(posedge clk) disable iff (rst)
        word_inc && !chunk_adv && !load |=> $stable(chunk)); // R5

endmodule

// File: rtl/fbp_retry.sv
module fbp_retry #(
    parameter int MAX_RETRY = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic exhausted
);
    localparam int RW = $clog2(MAX_RETRY + 1);

    logic [RW-1:0] cnt;

    assign exhausted = (cnt == RW'(MAX_RETRY));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc && !exhausted) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= RW'(MAX_RETRY)); // R6

endmodule

// File: rtl/fbp_engine.sv
module fbp_engine
    import fbp_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int BUF_WORDS   = 256,
    parameter int BLOCK_WORDS = 1024,
    parameter int MAX_RETRY   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [15:0]       host_wdata,
    output logic [7:0]        sts,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [15:0]       arr_wdata,
    input  logic [15:0]       arr_rdata
);
    localparam int WW = $clog2(BUF_WORDS);

    fbp_state_e state, state_nx;
    logic       seq_err, pgm_err;
    fbp_flags_t flags;

    logic              load_base, buf_clr, buf_wr, buf_last;
    logic              word_inc, chunk_adv, retry_clr, retry_inc, exhausted;
    logic              in_block, last_word, last_chunk, match, base_ok;
    logic [ADDR_W-1:0] base;
    logic [WW-1:0]     word_idx;

    fbp_addr_gen #(
        .ADDR_W      (ADDR_W),
        .BUF_WORDS   (BUF_WORDS),
        .BLOCK_WORDS (BLOCK_WORDS)
    ) addr_i (
        .clk            (clk),
        .rst            (rst),
        .load           (load_base),
        .load_addr      (host_addr),
        .word_inc       (word_inc),
        .chunk_adv      (chunk_adv),
        .probe_addr     (host_addr),
        .base           (base),
        .arr_addr       (arr_addr),
        .word_idx       (word_idx),
        .probe_in_block (in_block),
        .last_word      (last_word),
        .last_chunk     (last_chunk)
    );

    fbp_wbuf #(
        .DATA_W (16),
        .DEPTH  (BUF_WORDS)
    ) wbuf_i (
        .clk     (clk),
        .rst     (rst),
        .clr     (buf_clr),
        .wr_en   (buf_wr),
        .wr_data (host_wdata),
        .rd_idx  (word_idx),
        .rd_data (arr_wdata),
        .last_wr (buf_last)
    );

    fbp_retry #(
        .MAX_RETRY (MAX_RETRY)
    ) retry_i (
        .clk       (clk),
        .rst       (rst),
        .clr       (retry_clr),
        .inc       (retry_inc),
        .exhausted (exhausted)
    );

    assign match   = (arr_rdata == arr_wdata);
    assign base_ok = is_aligned(32'(base), BUF_WORDS);

    always_comb begin
        state_nx  = state;
        load_base = 1'b0;
        buf_clr   = 1'b0;
        buf_wr    = 1'b0;
        word_inc  = 1'b0;
        chunk_adv = 1'b0;
        retry_clr = 1'b0;
        retry_inc = 1'b0;
        arr_we    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (host_we && host_wdata == CMD_SETUP) begin
                    load_base = 1'b1;
                    buf_clr   = 1'b1;
                    retry_clr = 1'b1;
                    state_nx  = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (host_we) begin
                    state_nx = (host_wdata == CMD_CONFIRM && host_addr == base && base_ok)
                               ? ST_FILL : ST_IDLE;
                end
            end
            ST_FILL: begin
                if (host_we && in_block) begin
                    buf_wr = 1'b1;
                    if (buf_last) state_nx = ST_PGM;
                end else if (host_we && host_wdata == CMD_LEAVE) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_PGM: begin
                arr_we   = 1'b1;
                state_nx = ST_VFY;
            end
            ST_VFY: begin
                if (match) begin
                    retry_clr = 1'b1;
                    if (last_word) begin
                        chunk_adv = 1'b1;
                        buf_clr   = 1'b1;
                        state_nx  = last_chunk ? ST_IDLE : ST_FILL;
                    end else begin
                        word_inc = 1'b1;
                        state_nx = ST_PGM;
                    end
                end else if (exhausted) begin
                    state_nx = ST_IDLE;
                end else begin
                    retry_inc = 1'b1;
                    state_nx  = ST_PGM;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            seq_err <= 1'b0;
            pgm_err <= 1'b0;
        end else begin
            state <= state_nx;
            if (load_base) begin
                seq_err <= 1'b0;
                pgm_err <= 1'b0;
            end
            if (state == ST_SETUP && host_we && state_nx == ST_IDLE) begin
                seq_err <= 1'b1;
                pgm_err <= 1'b1;
            end
            if (state == ST_VFY && !match && exhausted) begin
                pgm_err <= 1'b1;
            end
        end
    end

    assign flags.ready   = (state == ST_IDLE);
    assign flags.seq_err = seq_err;
    assign flags.pgm_err = pgm_err;
    assign flags.busy    = (state == ST_PGM) || (state == ST_VFY);
    assign sts           = pack_status(flags);

    AST_PGM_THEN_READBACK: assert property (@(posedge clk) disable iff (rst)
        arr_we |=> !arr_we); // R6

    AST_NO_PGM_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
        sts[7] |-> !arr_we); // R9

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        sts[0] |-> !sts[7]); // R4

    AST_SEQ_ERR_ENDS_MODE: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_err) |-> sts[7]); // R3

    AST_PGM_ERR_ENDS_MODE: assert property (@(posedge clk) disable iff (rst)
        $rose(pgm_err) && !seq_err |-> sts[7] && $past(arr_addr) == arr_addr); // R7

    AST_FILL_NO_PGM: assert property (@(posedge clk) disable iff (rst)
        host_we && !sts[0] |=> !arr_we || $past(buf_last)); // R10

endmodule

// File: tb/fbp_engine_tb.sv
module fbp_engine_tb_top;

    localparam int AW    = 12;
    localparam int BUF   = 256;
    localparam int BLK   = 1024;
    localparam int NWORD = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [15:0]   host_wdata = '0;
    logic [7:0]    sts;
    logic          arr_we;
    logic [AW-1:0] arr_addr;
    logic [15:0]   arr_wdata;
    logic [15:0]   arr_rdata;

    logic [15:0] mem  [NWORD];
    logic [15:0] expm [NWORD];

    int          n_chk = 0;
    int          n_bad = 0;
    int          we_count = 0;
    int          fails_done = 0;
    int          fault_budget = 0;
    logic [AW-1:0] fault_addr = '0;
    logic        fault_rearm = 1'b0;
    int          cyc = 0;

    always #4 clk = ~clk;

    fbp_engine #(
        .ADDR_W      (AW),
        .BUF_WORDS   (BUF),
        .BLOCK_WORDS (BLK),
        .MAX_RETRY   (3)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .sts        (sts),
        .arr_we     (arr_we),
        .arr_addr   (arr_addr),
        .arr_wdata  (arr_wdata),
        .arr_rdata  (arr_rdata)
    );

    assign arr_rdata = mem[arr_addr];

    // Array model: stores a corrupted word for the first fault_budget attempts at fault_addr.
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NWORD; i++) mem[i] <= 16'hFFFF;
            we_count   <= 0;
            fails_done <= 0;
        end else begin
            if (fault_rearm) fails_done <= 0;
            if (arr_we) begin
                we_count <= we_count + 1;
                if (arr_addr == fault_addr && fails_done < fault_budget && !fault_rearm) begin
                    mem[arr_addr] <= arr_wdata ^ 16'h0001;
                    fails_done    <= fails_done + 1;
                end else begin
                    mem[arr_addr] <= arr_wdata;
                end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        host_we    = 1'b1;
        host_addr  = a[AW-1:0];
        host_wdata = d[15:0];
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    function automatic int buf_word_addr(input int base, input int k, input int i);
        return base + k * BUF + i;
    endfunction

    task automatic fill_buf(input int base, input int k, input bit put_ones);
        for (int i = 0; i < BUF; i++) begin
            int d;
            d = $urandom & 16'hFFFF;
            if (put_ones && i == 7) d = 16'hFFFF;
            expm[buf_word_addr(base, k, i)] = d[15:0];
            wr(buf_word_addr(base, k, i), d);
        end
    endtask

    task automatic wait_not_busy();
        for (int t = 0; t < 4000; t++) begin
            @(negedge clk);
            if (!sts[0]) break;
        end
    endtask

    task automatic arm_fault(input int a, input int n);
        @(negedge clk);
        fault_addr   = a[AW-1:0];
        fault_budget = n;
        fault_rearm  = 1'b1;
        @(negedge clk);
        fault_rearm  = 1'b0;
    endtask

    function automatic int count_mismatch();
        int bad = 0;
        for (int i = 0; i < NWORD; i++) if (mem[i] !== expm[i]) bad++;
        return bad;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int wc;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NWORD; i++) expm[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        chk("R1 status after reset", sts, 8'h80);
        chk("R1 no program strobe after reset", arr_we, 0);

        // Sequence errors
        wc = we_count;
        wr(12'h405, 16'h0080); wr(12'h405, 16'h00D0);
        chk("R3 misaligned setup", sts, 8'hB0);
        wr(12'h400, 16'h0080); wr(12'h400, 16'h1234);
        chk("R3 wrong confirm data", sts, 8'hB0);
        wr(12'h400, 16'h0080);
        chk("R11 errors cleared by setup", sts, 8'h00);
        wr(12'h401, 16'h00D0);
        chk("R3 confirm at other address", sts, 8'hB0);
        chk("R3 nothing programmed", we_count - wc, 0);

        // Full block at 0x400
        wr(12'h400, 16'h0080); wr(12'h400, 16'h00D0);
        chk("R2 mode entered", sts, 8'h00);
        for (int k = 0; k < BLK / BUF; k++) begin
            fill_buf(12'h400, k, 1'b0);
            chk("R4 busy after last buffer word", sts, 8'h01);
            wr(12'h400 + k * BUF, 16'hDEAD);
            wr(12'h4FF, 16'hBEEF);
            wait_not_busy();
            if (k < BLK / BUF - 1) chk("R4 ready for next fill", sts, 8'h00);
        end
        chk("R9 block end returns to ready", sts, 8'h80);
        chk("R5 R10 array contents after block", count_mismatch(), 0);

        // Retry that recovers, then early exit in block 0x000
        arm_fault(12'h005, 3);
        wr(12'h000, 16'h0080); wr(12'h000, 16'h00D0);
        wc = we_count;
        fill_buf(12'h000, 0, 1'b1);
        wait_not_busy();
        chk("R6 recovered on last retry", sts, 8'h00);
        chk("R6 program attempts", we_count - wc, BUF + 3);
        wr(12'hFFF, 16'h1234);
        chk("R10 outside non-exit write ignored", sts, 8'h00);
        wr(12'h100, 16'h1111); wr(12'h101, 16'h2222);
        wc = we_count;
        wr(12'hC00, 16'hFFFF);
        chk("R8 exit to ready", sts, 8'h80);
        repeat (10) @(negedge clk);
        chk("R8 partial buffer discarded", we_count - wc, 0);
        chk("R8 R6 array contents incl in-block FFFF", count_mismatch(), 0);

        // Retry exhaustion in block 0x800
        arm_fault(12'h80A, 4);
        wr(12'h800, 16'h0080); wr(12'h800, 16'h00D0);
        wc = we_count;
        for (int i = 0; i < BUF; i++) wr(12'h800 + i, i + 16'h0100);
        wait_not_busy();
        chk("R7 program error status", sts, 8'h90);
        chk("R7 attempts before abort", we_count - wc, 10 + 4);
        wc = we_count;
        for (int i = 0; i < 20; i++) wr(12'h800 + i, 16'h5555);
        repeat (10) @(negedge clk);
        chk("R7 writes after abort program nothing", we_count - wc, 0);
        chk("R7 status held", sts, 8'h90);
        wr(12'h800, 16'h0080);
        chk("R11 program error cleared", sts, 8'h00);
        wr(12'h800, 16'h00D0);
        chk("R2 re-entry after error", sts, 8'h00);
        wr(12'h000, 16'hFFFF);
        chk("R8 exit from empty fill", sts, 8'h80);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule